// File: doc/BRIEF.md
# I2C GPIO Expander Register Core

This block is a two-wire bus target that gives a controller access to sixteen general-purpose pins. The pins are split into two byte-wide banks, and each bank has its own byte in every register. The controller can read the pin levels, drive output values, choose the direction of each pin, invert the sense of input reads, and pick the pad keeper or pull behaviour. The bus lines reach the block already synchronized to its clock. The block drives SDA only through an open-drain enable.

A write transfer has three parts: the address byte, a command byte that loads a 4-bit register pointer, and any number of data bytes. A read transfer returns the register at the pointer. In both directions the pointer steps by one after every data byte and wraps from 15 to 0. Pin inputs pass through a two-flop synchronizer. They are captured into the input register on the rising SCL edge of the acknowledge bit that comes just before each read byte.

Top module: `i2c_pin_expander`

## Requirements
- R1: The target acknowledges an address byte only when its upper 7 bits equal {ADDR_HI, addr_pins} (default ADDR_HI = 3'b010). Bit 0 selects the direction: 1 is read, 0 is write. On a mismatch the target leaves sda_oe low until the next START.
- R2: In a write transfer the first byte after the address loads the pointer from its low 4 bits. Each data byte that follows is written to the register at the pointer and acknowledged. The pointer then steps by one, modulo 16.
- R3: In a read transfer each byte is the register at the pointer, sent MSB first, and the pointer then steps by one, modulo 16. Bytes continue while the controller acknowledges. After a NACK the target releases SDA.
- R4: The pointer is laid out as {kind[2:0], bank}. Bank 0 covers pins 7:0 and bank 1 covers pins 15:8. The kinds are 0 input, 1 output, 2 invert, 3 direction, 4 keeper, 5 pull-select. Kinds 6 and 7 read as 0x00 and ignore writes.
- R5: Reading the input register returns the synchronized pin levels XOR the invert register. The levels are captured at the start of each read byte.
- R6: pin_oe is the inverse of the direction register (1 means input). pin_out follows the output register whatever the direction.
- R7: hold_en follows the keeper register. pull_up is high only where the keeper bit is 0 and the pull-select bit is 1. pull_dn is high only where the keeper bit is 0 and the pull-select bit is 0.
- R8: After reset every pin is an input, invert is 0x00, output is 0xFF, the keeper is enabled, pull-select is 0x00, and sda_oe is low.
- R9: Writes to the input register are acknowledged but have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| addr_pins | input | 4 | Low address bits from board straps |
| pin_in | input | 16 | Raw pin levels |
| pin_out | output | 16 | Value to drive on each pin |
| pin_oe | output | 16 | Per-pin output enable |
| hold_en | output | 16 | Per-pin keeper enable |
| pull_up | output | 16 | Per-pin pull-up enable |
| pull_dn | output | 16 | Per-pin pull-down enable |

## Verification
The bench builds the block with its defaults: two 8-bit banks, a 4-bit pointer and fixed upper address bits 010. With these values the pointer space holds the unmapped codes 12 to 15, so the bench can check that those codes read as zero and ignore writes. It also covers the wrap from 15 back to 0 and a multi-byte read that crosses from the output registers into the invert registers. Because the strap input is the only variable part of the address, changing addr_pins in the middle of the run shows that an old address is refused and a new one is accepted.

// File: rtl/pinx_pkg.sv
package pinx_pkg;
  localparam int BYTE_W = 8;

  // register kinds held in the upper pointer bits
  localparam int K_IN   = 0;
  localparam int K_OUT  = 1;
  localparam int K_INV  = 2;
  localparam int K_DIR  = 3;
  localparam int K_HOLD = 4;
  localparam int K_PSEL = 5;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_CMD,
    ST_CMD_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK
  } bus_state_e;
endpackage

// File: rtl/pinx_sync.sv
module pinx_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/pinx_bus.sv
module pinx_bus
  import pinx_pkg::*;
#(
  parameter int                   ADDR_HI_W = 3,
  parameter logic [ADDR_HI_W-1:0] ADDR_HI   = 3'b010,
  parameter int                   PTR_W     = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                scl_i,
  input  logic                sda_i,
  input  logic [6-ADDR_HI_W:0] addr_pins,
  output logic                sda_oe,
  output logic [PTR_W-1:0]    ptr,
  output logic                wr_en,
  output logic [BYTE_W-1:0]   wr_data,
  output logic                capture,
  output logic                load_now,
  input  logic [BYTE_W-1:0]   rd_data
);
  bus_state_e          state;
  logic                scl_q, sda_q;
  logic [BYTE_W-1:0]   shift;
  logic [3:0]          bitcnt;
  logic                rw_q;
  logic                host_ack;
  logic                rise, fall, start_c, stop_c, byte_done;
  logic [6:0]          my_addr;

  assign my_addr   = {ADDR_HI, addr_pins};
  assign rise      = scl_i & ~scl_q;
  assign fall      = ~scl_i & scl_q;
  assign start_c   = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_c    = scl_i & scl_q & ~sda_q & sda_i;
  assign byte_done = fall && (bitcnt == 4'd8);
  assign wr_data   = shift;

  always_comb begin
    load_now = 1'b0;
    wr_en    = 1'b0;
    capture  = 1'b0;
    if (!start_c && !stop_c) begin
      case (state)
        ST_ADDR_ACK: begin
          load_now = fall && rw_q;
          capture  = rise && rw_q;
        end
        ST_RACK: begin
          load_now = fall && host_ack;
          capture  = rise;
        end
        ST_WDATA: wr_en = byte_done;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
      shift    <= '0;
      bitcnt   <= '0;
      rw_q     <= 1'b0;
      host_ack <= 1'b0;
      sda_oe   <= 1'b0;
      ptr      <= '0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      if (start_c) begin
        state  <= ST_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_c) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_CMD, ST_WDATA: begin
            if (rise && bitcnt < 4'd8) begin
              shift  <= {shift[BYTE_W-2:0], sda_i};
              bitcnt <= bitcnt + 4'd1;
            end
            if (byte_done) begin
              if (state == ST_ADDR) begin
                if (shift[7:1] == my_addr) begin
                  rw_q   <= shift[0];
                  sda_oe <= 1'b1;
                  state  <= ST_ADDR_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else if (state == ST_CMD) begin
                ptr    <= shift[PTR_W-1:0];
                sda_oe <= 1'b1;
                state  <= ST_CMD_ACK;
              end else begin
                ptr    <= ptr + PTR_W'(1);
                sda_oe <= 1'b1;
                state  <= ST_WDATA_ACK;
              end
            end
          end
          ST_ADDR_ACK, ST_CMD_ACK, ST_WDATA_ACK: begin
            if (fall) begin
              bitcnt <= '0;
              if (load_now) begin
                shift  <= rd_data;
                sda_oe <= ~rd_data[BYTE_W-1];
                ptr    <= ptr + PTR_W'(1);
                state  <= ST_RDATA;
              end else begin
                sda_oe <= 1'b0;
                state  <= (state == ST_ADDR_ACK) ? ST_CMD : ST_WDATA;
              end
            end
          end
          ST_RDATA: begin
            if (fall) begin
              if (bitcnt == 4'd7) begin
                sda_oe <= 1'b0;
                state  <= ST_RACK;
              end else begin
                sda_oe <= ~shift[BYTE_W-2];
                shift  <= {shift[BYTE_W-2:0], 1'b0};
                bitcnt <= bitcnt + 4'd1;
              end
            end
          end
          ST_RACK: begin
            if (rise) host_ack <= ~sda_i;
            if (fall) begin
              bitcnt <= '0;
              if (load_now) begin
                shift  <= rd_data;
                sda_oe <= ~rd_data[BYTE_W-1];
                ptr    <= ptr + PTR_W'(1);
                state  <= ST_RDATA;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_IDLE;
              end
            end
          end
          default: sda_oe <= 1'b0;
        endcase
      end
    end
  end

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !sda_oe); // R1
  AST_WRITE_STEP: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ptr == $past(ptr) + PTR_W'(1)); // R2
  AST_READ_STEP: assert property (@(posedge clk) disable iff (rst)
    load_now |=> ptr == $past(ptr) + PTR_W'(1)); // R3
endmodule

// File: rtl/pinx_regs.sv
module pinx_regs
  import pinx_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int PTR_W     = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [PTR_W-1:0]              ptr,
  input  logic [BYTE_W-1:0]             wr_data,
  input  logic                          capture,
  input  logic [NUM_BANKS*BYTE_W-1:0]   pin_sync,
  output logic [BYTE_W-1:0]             rd_data,
  output logic [NUM_BANKS*BYTE_W-1:0]   pin_out,
  output logic [NUM_BANKS*BYTE_W-1:0]   pin_oe,
  output logic [NUM_BANKS*BYTE_W-1:0]   hold_en,
  output logic [NUM_BANKS*BYTE_W-1:0]   pull_up,
  output logic [NUM_BANKS*BYTE_W-1:0]   pull_dn
);
  localparam int N      = NUM_BANKS * BYTE_W;
  localparam int BSEL_W = $clog2(NUM_BANKS);
  localparam int KIND_W = PTR_W - BSEL_W;

  logic [N-1:0]        in_flat, out_flat, inv_flat, dir_flat, hold_flat, psel_flat;
  logic [BSEL_W-1:0]   bsel;
  logic [KIND_W-1:0]   kind;

  assign bsel = ptr[BSEL_W-1:0];
  assign kind = ptr[PTR_W-1:BSEL_W];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic                hit;
    logic [BYTE_W-1:0]   in_q, out_q, inv_q, dir_q, hold_q, psel_q;

    assign hit = wr_en && (bsel == BSEL_W'(b));

    always_ff @(posedge clk) begin
      if (rst) begin
        in_q   <= '0;
        out_q  <= '1;
        inv_q  <= '0;
        dir_q  <= '1;
        hold_q <= '1;
        psel_q <= '0;
      end else begin
        if (capture) in_q <= pin_sync[b*BYTE_W +: BYTE_W];
        if (hit) begin
          if (kind == KIND_W'(K_OUT))  out_q  <= wr_data;
          if (kind == KIND_W'(K_INV))  inv_q  <= wr_data;
          if (kind == KIND_W'(K_DIR))  dir_q  <= wr_data;
          if (kind == KIND_W'(K_HOLD)) hold_q <= wr_data;
          if (kind == KIND_W'(K_PSEL)) psel_q <= wr_data;
        end
      end
    end

    assign in_flat[b*BYTE_W +: BYTE_W]   = in_q;
    assign out_flat[b*BYTE_W +: BYTE_W]  = out_q;
    assign inv_flat[b*BYTE_W +: BYTE_W]  = inv_q;
    assign dir_flat[b*BYTE_W +: BYTE_W]  = dir_q;
    assign hold_flat[b*BYTE_W +: BYTE_W] = hold_q;
    assign psel_flat[b*BYTE_W +: BYTE_W] = psel_q;
  end

  always_comb begin
    rd_data = '0;
    if (int'(bsel) < NUM_BANKS) begin
      case (int'(kind))
        K_IN:   rd_data = in_flat[bsel*BYTE_W +: BYTE_W] ^ inv_flat[bsel*BYTE_W +: BYTE_W];
        K_OUT:  rd_data = out_flat[bsel*BYTE_W +: BYTE_W];
        K_INV:  rd_data = inv_flat[bsel*BYTE_W +: BYTE_W];
        K_DIR:  rd_data = dir_flat[bsel*BYTE_W +: BYTE_W];
        K_HOLD: rd_data = hold_flat[bsel*BYTE_W +: BYTE_W];
        K_PSEL: rd_data = psel_flat[bsel*BYTE_W +: BYTE_W];
        default: rd_data = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out <= '1;
      pin_oe  <= '0;
      hold_en <= '1;
      pull_up <= '0;
      pull_dn <= '0;
    end else begin
      pin_out <= out_flat;
      pin_oe  <= ~dir_flat;
      hold_en <= hold_flat;
      pull_up <= ~hold_flat & psel_flat;
      pull_dn <= ~hold_flat & ~psel_flat;
    end
  end

  AST_OE_FOLLOWS_DIR: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> pin_oe == ~$past(dir_flat)); // R6
  AST_HOLD_GATES_PULL: assert property (@(posedge clk) disable iff (rst)
    ((hold_en & (pull_up | pull_dn)) == '0) && ((pull_up & pull_dn) == '0)); // R7
  AST_IN_ONLY_ON_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    !capture |=> $stable(in_flat)); // R9
endmodule

// File: rtl/i2c_pin_expander.sv
module i2c_pin_expander
  import pinx_pkg::*;
#(
  parameter int       ADDR_HI_W = 3,
  parameter logic [2:0] ADDR_HI = 3'b010,
  parameter int       NUM_BANKS = 2,
  parameter int       PTR_W     = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        scl_i,
  input  logic                        sda_i,
  output logic                        sda_oe,
  input  logic [3:0]                  addr_pins,
  input  logic [NUM_BANKS*8-1:0]      pin_in,
  output logic [NUM_BANKS*8-1:0]      pin_out,
  output logic [NUM_BANKS*8-1:0]      pin_oe,
  output logic [NUM_BANKS*8-1:0]      hold_en,
  output logic [NUM_BANKS*8-1:0]      pull_up,
  output logic [NUM_BANKS*8-1:0]      pull_dn
);
  localparam int N = NUM_BANKS * BYTE_W;

  logic [N-1:0]      pin_sync;
  logic [PTR_W-1:0]  ptr;
  logic              wr_en, capture, load_now;
  logic [BYTE_W-1:0] wr_data, rd_data;

  pinx_sync #(.W(N)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(pin_sync)
  );

  pinx_bus #(
    .ADDR_HI_W(ADDR_HI_W), .ADDR_HI(ADDR_HI), .PTR_W(PTR_W)
  ) u_bus (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .addr_pins(addr_pins), .sda_oe(sda_oe), .ptr(ptr),
    .wr_en(wr_en), .wr_data(wr_data), .capture(capture),
    .load_now(load_now), .rd_data(rd_data)
  );

  pinx_regs #(.NUM_BANKS(NUM_BANKS), .PTR_W(PTR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .ptr(ptr), .wr_data(wr_data),
    .capture(capture), .pin_sync(pin_sync), .rd_data(rd_data),
    .pin_out(pin_out), .pin_oe(pin_oe), .hold_en(hold_en),
    .pull_up(pull_up), .pull_dn(pull_dn)
  );
endmodule

// File: tb/i2c_pin_expander_tb.sv
module i2c_pin_expander_tb;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic scl_d = 1'b1, sda_d = 1'b1;
  logic sda_oe, sda_line;
  logic [3:0]  addr_pins = 4'h5;
  logic [15:0] pin_in = 16'h0000;
  logic [15:0] pin_out, pin_oe, hold_en, pull_up, pull_dn;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  string       exp_tag_q[$];
  logic [7:0]  exp_val_q[$];
  logic [7:0]  act_q[$];

  assign sda_line = sda_d & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_pin_expander u_dut (
    .clk(clk), .rst(rst), .scl_i(scl_d), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_pins(addr_pins), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .hold_en(hold_en), .pull_up(pull_up), .pull_dn(pull_dn)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_d = 1'b1; waitq(Q); scl_d = 1'b1; waitq(Q);
    sda_d = 1'b0; waitq(Q); scl_d = 1'b0; waitq(Q);
  endtask

  task automatic i2c_stop();
    sda_d = 1'b0; waitq(Q); scl_d = 1'b1; waitq(Q);
    sda_d = 1'b1; waitq(2*Q);
  endtask

  task automatic send_bit(input logic b);
    sda_d = b; waitq(Q); scl_d = 1'b1; waitq(2*Q); scl_d = 1'b0; waitq(Q);
  endtask

  task automatic recv_bit(output logic v);
    sda_d = 1'b1; waitq(Q); scl_d = 1'b1; waitq(Q);
    v = sda_line; waitq(Q); scl_d = 1'b0; waitq(Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, input logic exp_nack, input string tag);
    logic a;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    recv_bit(a);
    chk(a == exp_nack, tag, a, exp_nack);
  endtask

  task automatic expect_byte(input string tag, input logic [7:0] v);
    exp_tag_q.push_back(tag);
    exp_val_q.push_back(v);
  endtask

  task automatic rd_byte(input bit ack);
    logic [7:0] v;
    for (int i = 7; i >= 0; i--) recv_bit(v[i]);
    send_bit(!ack);
    act_q.push_back(v);
  endtask

  // write a pointer, then read n bytes back via a repeated start
  task automatic set_ptr_read(input logic [7:0] addr7, input logic [3:0] p, input int n, input string tag);
    i2c_start();
    wr_byte({addr7[6:0], 1'b0}, 1'b0, tag);
    wr_byte({4'h0, p}, 1'b0, tag);
    i2c_start();
    wr_byte({addr7[6:0], 1'b1}, 1'b0, tag);
    for (int i = 0; i < n; i++) rd_byte(i != n - 1);
    i2c_stop();
  endtask

  task automatic write_regs(input logic [6:0] addr7, input logic [3:0] p,
                            input logic [7:0] d0, input logic [7:0] d1, input string tag);
    i2c_start();
    wr_byte({addr7, 1'b0}, 1'b0, tag);
    wr_byte({4'h0, p}, 1'b0, tag);
    wr_byte(d0, 1'b0, tag);
    wr_byte(d1, 1'b0, tag);
    i2c_stop();
  endtask

  // monitor: compares read bytes with the scoreboard in order
  initial begin
    forever begin
      wait (act_q.size() > 0);
      begin
        logic [7:0] a, e;
        string t;
        a = act_q.pop_front();
        if (exp_val_q.size() == 0) begin
          chk(1'b0, "scoreboard empty", {24'h0, a}, 32'h0);
        end else begin
          e = exp_val_q.pop_front();
          t = exp_tag_q.pop_front();
          chk(a == e, t, {24'h0, a}, {24'h0, e});
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  localparam logic [6:0] ADDR = 7'h25;

  initial begin
    logic v;
    waitq(5);
    rst = 1'b0;
    waitq(2);
    // R8 reset state
    chk(pin_oe == 16'h0000, "R8 pin_oe reset", pin_oe, 16'h0000);
    chk(pin_out == 16'hFFFF, "R8 pin_out reset", pin_out, 16'hFFFF);
    chk(hold_en == 16'hFFFF, "R8 hold_en reset", hold_en, 16'hFFFF);
    chk((pull_up | pull_dn) == 16'h0, "R8 pulls reset", pull_up | pull_dn, 16'h0);
    chk(sda_oe == 1'b0, "R8 sda_oe reset", sda_oe, 1'b0);

    // R1 wrong address is refused
    i2c_start();
    wr_byte(8'h4C, 1'b1, "R1 mismatch nack");
    i2c_stop();

    // R2 / R6 output registers with auto-increment
    write_regs(ADDR, 4'd2, 8'hA5, 8'h3C, "R2 write out");
    waitq(4);
    chk(pin_out == 16'h3CA5, "R6 pin_out", pin_out, 16'h3CA5);
    chk(pin_oe == 16'h0000, "R6 still inputs", pin_oe, 16'h0000);

    write_regs(ADDR, 4'd6, 8'h00, 8'hF0, "R2 write dir");
    waitq(4);
    chk(pin_oe == 16'h0FFF, "R6 pin_oe", pin_oe, 16'h0FFF);

    // R5 input read, no inversion
    pin_in = 16'h1234;
    waitq(4);
    expect_byte("R5 in0", 8'h34);
    expect_byte("R5 in1", 8'h12);
    set_ptr_read(ADDR, 4'd0, 2, "R3 read setup");

    // R5 inverted read
    write_regs(ADDR, 4'd4, 8'hFF, 8'h0F, "R2 write inv");
    expect_byte("R5 inv in0", 8'hCB);
    expect_byte("R5 inv in1", 8'h1D);
    set_ptr_read(ADDR, 4'd0, 2, "R5 read setup");

    // R3 read across kinds, then SDA released after NACK
    expect_byte("R3 out0", 8'hA5);
    expect_byte("R3 out1", 8'h3C);
    expect_byte("R3 inv0", 8'hFF);
    expect_byte("R3 inv1", 8'h0F);
    i2c_start();
    wr_byte({ADDR, 1'b0}, 1'b0, "R3 addr w");
    wr_byte(8'h02, 1'b0, "R3 cmd");
    i2c_start();
    wr_byte({ADDR, 1'b1}, 1'b0, "R3 addr r");
    for (int i = 0; i < 4; i++) rd_byte(i != 3);
    recv_bit(v);
    chk(v == 1'b1, "R3 released after nack", v, 1'b1);
    i2c_stop();

    // R7 keeper and pull selection
    i2c_start();
    wr_byte({ADDR, 1'b0}, 1'b0, "R7 addr");
    wr_byte(8'h08, 1'b0, "R7 cmd");
    wr_byte(8'h00, 1'b0, "R7 hold0");
    wr_byte(8'hFF, 1'b0, "R7 hold1");
    wr_byte(8'h0F, 1'b0, "R7 psel0");
    wr_byte(8'h00, 1'b0, "R7 psel1");
    i2c_stop();
    waitq(4);
    chk(hold_en == 16'hFF00, "R7 hold_en", hold_en, 16'hFF00);
    chk(pull_up == 16'h000F, "R7 pull_up", pull_up, 16'h000F);
    chk(pull_dn == 16'h00F0, "R7 pull_dn", pull_dn, 16'h00F0);

    // R4 unmapped codes read zero and ignore writes
    write_regs(ADDR, 4'd12, 8'h55, 8'h55, "R4 write unmapped");
    waitq(4);
    chk(pin_out == 16'h3CA5 && pin_oe == 16'h0FFF, "R4 outputs unchanged", pin_out, 16'h3CA5);
    expect_byte("R4 unmapped 12", 8'h00);
    expect_byte("R4 unmapped 13", 8'h00);
    set_ptr_read(ADDR, 4'd12, 2, "R4 read setup");

    // R9 writes to input register ignored
    write_regs(ADDR, 4'd0, 8'h00, 8'h00, "R9 write in");
    expect_byte("R9 in0 kept", 8'hCB);
    expect_byte("R9 in1 kept", 8'h1D);
    set_ptr_read(ADDR, 4'd0, 2, "R9 read setup");

    // R2 pointer wraps from 15 to 0
    expect_byte("R2 wrap ptr15", 8'h00);
    expect_byte("R2 wrap ptr0", 8'hCB);
    set_ptr_read(ADDR, 4'd15, 2, "R2 wrap setup");

    // R5 new pin levels captured at start of each read byte
    pin_in = 16'hFFFF;
    waitq(4);
    expect_byte("R5 new in0", 8'h00);
    expect_byte("R5 new in1", 8'hF0);
    set_ptr_read(ADDR, 4'd0, 2, "R5 new setup");

    // R1 address follows the strap pins
    addr_pins = 4'hA;
    waitq(4);
    i2c_start();
    wr_byte({ADDR, 1'b0}, 1'b1, "R1 old addr nack");
    i2c_stop();
    i2c_start();
    wr_byte({3'b010, 4'hA, 1'b0}, 1'b0, "R1 new addr ack");
    i2c_stop();

    wait (act_q.size() == 0);
    waitq(4);
    chk(exp_val_q.size() == 0, "scoreboard drained", exp_val_q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule